// File: doc/BRIEF.md
# Three-Stage Forwarding Pipeline Core

This block is a small in-order integer core with three stages: fetch, execute and writeback. Each cycle it presents its program counter on `pc_o`. An instruction store outside the block answers at once, in the same cycle, with an opcode, two source register numbers and a destination register number. The next program counter is always the current one plus one. Operands are read from an internal register file, the result comes from a combinational ALU, and the architectural register contents are exposed on a flat output bus.

Two data hazards are handled, each in a different way. When the instruction in execute will write the register that the fetched instruction uses as its first operand, fetch stalls for one cycle. A second operand that depends on the instruction one step ahead is taken from the writeback result. Dependencies two steps apart need no logic at all, because register reads at fetch see that cycle's writeback write. An external `flush` input turns the instruction being fetched into a bubble and holds the program counter.

Top module: `fwd_pipe_core`

## Requirements
- R1: With `rst_n` low at a rising edge, the program counter becomes 0, register i becomes `RF_INIT_BASE + i*RF_INIT_STEP` (truncated to `DATA_W`), and both pipeline valid bits are cleared.
- R2: When neither `flush` nor a stall is active, `pc_o` increases by one (modulo 2^`PC_W`) at the next edge. When either is active, `pc_o` keeps its value.
- R3: A stall occurs when execute holds a valid instruction whose destination equals the first source register being fetched. The fetch is then retried one cycle later, and two stalls never occur back to back.
- R4: The second ALU operand is the writeback result when writeback is valid and its destination equals the execute stage's second source register. Otherwise it is the value read at fetch.
- R5: Both source reads at fetch return the value being written by writeback in the same cycle when the register numbers match.
- R6: An instruction fetched while `flush` or a stall is active becomes a bubble and never changes the register file. The register file changes only when writeback is valid.
- R7: Opcode encoding: 2'b00 add, 2'b01 subtract (first minus second), 2'b10 bitwise and, 2'b11 bitwise xor. All results wrap to `DATA_W` bits.
- R8: An instruction fetched in cycle t updates the register file at the third rising edge after cycle t begins, and not earlier. The writeback valid bit always equals the execute valid bit of the cycle before.
- R9: Executing any program under this pipeline leaves the register file equal to executing the same instructions one at a time in program order, each exactly once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| flush | input | 1 | Squash the instruction being fetched and hold the program counter |
| pc_o | output | PC_W | Architectural program counter, used as the instruction store address |
| fetch_op | input | 2 | Opcode of the instruction at `pc_o` |
| fetch_src1 | input | REG_AW | First source register of the instruction at `pc_o` |
| fetch_src2 | input | REG_AW | Second source register of the instruction at `pc_o` |
| fetch_dest | input | REG_AW | Destination register of the instruction at `pc_o` |
| rf_o | output | NUM_REGS*DATA_W | Register file contents, register i at bits [i*DATA_W +: DATA_W] |

## Verification
A change of the program counter shows up one edge after the fetch cycle that caused it. A written register shows up on `rf_o` three edges after its instruction was fetched, so the latency check reads the bus at the falling edge after the second and after the third rising edge. Program runs count rising edges until `pc_o` reaches the program length, and compare that count with the program length plus the first-operand dependencies that the bench predicts. After that the bench holds `flush` for three more edges, so the pipeline drains before the register file is compared with an in-order model.

// File: rtl/fwd_pipe_pkg.sv
// Package: shared opcode encoding for the forwarding pipeline core.
// Assumes opcodes are exactly two bits wide; widths of data, registers and
// program counter are parameters of the modules, not of this package.
package fwd_pipe_pkg;

    localparam int OP_W = 2;

    typedef enum logic [OP_W-1:0] {
        ALU_ADD = 2'b00,
        ALU_SUB = 2'b01,
        ALU_AND = 2'b10,
        ALU_XOR = 2'b11
    } alu_op_e;

endpackage

// File: rtl/fwd_pipe_alu.sv
// Module: combinational ALU of the execute stage.
// Computes add, subtract, and, xor on DATA_W-bit operands; results wrap.
// Assumes the opcode is already a legal alu_op_e value (all four codes are).
module fwd_pipe_alu
    import fwd_pipe_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  alu_op_e             op,
    input  logic [DATA_W-1:0]   opnd_a,
    input  logic [DATA_W-1:0]   opnd_b,
    output logic [DATA_W-1:0]   result
);

    // Select the operation named by the opcode.
    always_comb begin
        unique case (op)
            ALU_ADD: result = opnd_a + opnd_b;
            ALU_SUB: result = opnd_a - opnd_b;
            ALU_AND: result = opnd_a & opnd_b;
            ALU_XOR: result = opnd_a ^ opnd_b;
            default: result = '0;
        endcase
    end

endmodule

// File: rtl/fwd_pipe_regfile.sv
// Module: architectural register file with one write port and two
// write-through read ports.
// Reads return the value being written in the same cycle when the addresses
// match, so fetch never has to guard against the writeback stage.
// Assumes NUM_REGS is a power of two so every address names a register.
// Register i resets to RF_INIT_BASE + i*RF_INIT_STEP (truncated).
module fwd_pipe_regfile #(
    parameter int                 NUM_REGS     = 8,
    parameter int                 DATA_W       = 16,
    parameter logic [DATA_W-1:0]  RF_INIT_BASE = '0,
    parameter logic [DATA_W-1:0]  RF_INIT_STEP = '0,
    localparam int                REG_AW       = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int                FLAT_W       = NUM_REGS * DATA_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [REG_AW-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [REG_AW-1:0]    rd_addr_a,
    input  logic [REG_AW-1:0]    rd_addr_b,
    output logic [DATA_W-1:0]    rd_data_a,
    output logic [DATA_W-1:0]    rd_data_b,
    output logic [FLAT_W-1:0]    rf_flat
);

    logic [DATA_W-1:0] view [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam logic [DATA_W-1:0] INIT_VAL =
            RF_INIT_BASE + (DATA_W'(g) * RF_INIT_STEP);

        logic [DATA_W-1:0] q;

        // Hold one register; load on reset or on a matching valid write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= INIT_VAL;
            end else if (wr_en && (wr_addr == REG_AW'(g))) begin
                q <= wr_data;
            end
        end

        assign view[g]                       = q;
        assign rf_flat[g*DATA_W +: DATA_W]   = q;
    end

    // Port A read with write-through of the current write.
    always_comb begin
        rd_data_a = view[rd_addr_a];
        if (wr_en && (wr_addr == rd_addr_a)) begin
            rd_data_a = wr_data;
        end
    end

    // Port B read with write-through of the current write.
    always_comb begin
        rd_data_b = view[rd_addr_b];
        if (wr_en && (wr_addr == rd_addr_b)) begin
            rd_data_b = wr_data;
        end
    end

endmodule

// File: rtl/fwd_pipe_hazard.sv
// Module: hazard unit of the pipeline.
// Raises a stall when the valid execute instruction writes the first source
// of the fetched instruction, and selects the second ALU operand from the
// writeback result when writeback targets the execute second source.
// Assumes the first operand is never forwarded: stalling alone protects it.
module fwd_pipe_hazard #(
    parameter int  DATA_W = 16,
    parameter int  REG_AW = 3
) (
    input  logic                 exe_vld,
    input  logic [REG_AW-1:0]    exe_dest,
    input  logic [REG_AW-1:0]    fet_src1,
    input  logic                 wbk_vld,
    input  logic [REG_AW-1:0]    wbk_dest,
    input  logic [DATA_W-1:0]    wbk_val,
    input  logic [REG_AW-1:0]    exe_src2,
    input  logic [DATA_W-1:0]    exe_arg2,
    output logic                 stall,
    output logic                 fwd_hit,
    output logic [DATA_W-1:0]    opnd_b
);

    // Detect the first-operand dependence on the execute stage.
    always_comb begin
        stall = exe_vld && (exe_dest == fet_src1);
    end

    // Pick the second operand: bypass from writeback or the captured value.
    always_comb begin
        fwd_hit = wbk_vld && (wbk_dest == exe_src2);
        opnd_b  = fwd_hit ? wbk_val : exe_arg2;
    end

endmodule

// File: rtl/fwd_pipe_core.sv
// Module: top of the three-stage in-order core (fetch, execute, writeback).
// Fetch presents pc_o; an outside instruction store answers combinationally
// with opcode and register fields. The next PC is PC+1. Operands are read
// from the register file through its same-cycle write, the second operand
// may be bypassed from writeback, and a first-operand dependence on execute
// costs one stall cycle. flush squashes the fetched instruction.
// Assumes the instruction fields are stable during the cycle they are used.
module fwd_pipe_core
    import fwd_pipe_pkg::*;
#(
    parameter int                 NUM_REGS     = 8,
    parameter int                 DATA_W       = 16,
    parameter int                 PC_W         = 8,
    parameter logic [DATA_W-1:0]  RF_INIT_BASE = '0,
    parameter logic [DATA_W-1:0]  RF_INIT_STEP = '0,
    localparam int                REG_AW       = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int                FLAT_W       = NUM_REGS * DATA_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flush,
    output logic [PC_W-1:0]      pc_o,
    input  logic [OP_W-1:0]      fetch_op,
    input  logic [REG_AW-1:0]    fetch_src1,
    input  logic [REG_AW-1:0]    fetch_src2,
    input  logic [REG_AW-1:0]    fetch_dest,
    output logic [FLAT_W-1:0]    rf_o
);

    localparam logic [PC_W-1:0] PC_STEP = PC_W'(1);

    // Fetch stage state and decode.
    logic [PC_W-1:0]     pc_q;
    logic                stall;
    logic                advance;
    logic [DATA_W-1:0]   rd_val_a;
    logic [DATA_W-1:0]   rd_val_b;

    // Execute stage registers.
    logic                e_vld;
    alu_op_e             e_op;
    logic [REG_AW-1:0]   e_src2;
    logic [REG_AW-1:0]   e_dest;
    logic [DATA_W-1:0]   e_arg1;
    logic [DATA_W-1:0]   e_arg2;

    // Writeback stage registers.
    logic                w_vld;
    logic [REG_AW-1:0]   w_dest;
    logic [DATA_W-1:0]   w_val;

    // Execute datapath.
    logic                fwd_hit;
    logic [DATA_W-1:0]   opnd_b;
    logic [DATA_W-1:0]   alu_y;

    // A fetch is accepted only when neither flush nor stall holds it.
    always_comb begin
        advance = !(flush || stall);
    end

    // Program counter: clear on reset, step by one on an accepted fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else if (advance) begin
            pc_q <= pc_q + PC_STEP;
        end
    end

    assign pc_o = pc_q;

    // Fetch-to-execute register: capture fields, mark bubble if not accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_vld  <= 1'b0;
            e_op   <= ALU_ADD;
            e_src2 <= '0;
            e_dest <= '0;
            e_arg1 <= '0;
            e_arg2 <= '0;
        end else begin
            e_vld  <= advance;
            e_op   <= alu_op_e'(fetch_op);
            e_src2 <= fetch_src2;
            e_dest <= fetch_dest;
            e_arg1 <= rd_val_a;
            e_arg2 <= rd_val_b;
        end
    end

    // Execute-to-writeback register: copy valid, destination and result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_vld  <= 1'b0;
            w_dest <= '0;
            w_val  <= '0;
        end else begin
            w_vld  <= e_vld;
            w_dest <= e_dest;
            w_val  <= alu_y;
        end
    end

    fwd_pipe_regfile #(
        .NUM_REGS     (NUM_REGS),
        .DATA_W       (DATA_W),
        .RF_INIT_BASE (RF_INIT_BASE),
        .RF_INIT_STEP (RF_INIT_STEP)
    ) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (w_vld),
        .wr_addr   (w_dest),
        .wr_data   (w_val),
        .rd_addr_a (fetch_src1),
        .rd_addr_b (fetch_src2),
        .rd_data_a (rd_val_a),
        .rd_data_b (rd_val_b),
        .rf_flat   (rf_o)
    );

    fwd_pipe_hazard #(
        .DATA_W (DATA_W),
        .REG_AW (REG_AW)
    ) u_haz (
        .exe_vld  (e_vld),
        .exe_dest (e_dest),
        .fet_src1 (fetch_src1),
        .wbk_vld  (w_vld),
        .wbk_dest (w_dest),
        .wbk_val  (w_val),
        .exe_src2 (e_src2),
        .exe_arg2 (e_arg2),
        .stall    (stall),
        .fwd_hit  (fwd_hit),
        .opnd_b   (opnd_b)
    );

    fwd_pipe_alu #(
        .DATA_W (DATA_W)
    ) u_alu (
        .op     (e_op),
        .opnd_a (e_arg1),
        .opnd_b (opnd_b),
        .result (alu_y)
    );

endmodule

// File: rtl/fwd_pipe_checker.sv
// Module: property checker for fwd_pipe_core, attached by bind below.
// Watches program counter, flush, stall, the two valid bits and the
// register file bus; all properties are disabled while reset is low.
module fwd_pipe_checker #(
    parameter int PC_W = 8,
    parameter int RF_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              stall,
    input  logic [PC_W-1:0]   pc,
    input  logic              e_vld,
    input  logic              w_vld,
    input  logic [RF_W-1:0]   rf
);

    // R2: an accepted fetch steps the program counter by one.
    p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && !stall) |=> (pc == ($past(pc) + PC_W'(1))));

    // R2: flush or stall holds the program counter.
    p_pc_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (flush || stall) |=> $stable(pc));

    // R3: a retried fetch never stalls a second time in a row.
    p_single_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall);

    // R6: a squashed or stalled fetch enters execute as a bubble.
    p_bubble_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flush || stall) |=> !e_vld);

    // R6: without a valid writeback the register file does not change.
    p_rf_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !w_vld |=> $stable(rf));

    // R8: writeback validity trails execute validity by one cycle.
    p_wb_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        e_vld |=> w_vld);

endmodule

bind fwd_pipe_core fwd_pipe_checker #(
    .PC_W (PC_W),
    .RF_W (NUM_REGS * DATA_W)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush),
    .stall (stall),
    .pc    (pc_o),
    .e_vld (e_vld),
    .w_vld (w_vld),
    .rf    (rf_o)
);

// File: tb/sim_fwd_pipe_core.sv
// Bench: directed scenarios for fwd_pipe_core; the bench acts as the
// instruction store and holds an in-order reference model of the registers.
module sim_fwd_pipe_core;

    localparam int          CLK_PERIOD = 10;
    localparam int          NR   = 8;
    localparam int          DW   = 16;
    localparam int          PW   = 8;
    localparam int          AW   = 3;
    localparam int          MAXP = 16;
    localparam logic [15:0] IB   = 16'h0011;
    localparam logic [15:0] IS   = 16'h0101;

    logic              clk   = 1'b0;
    logic              rst_n = 1'b0;
    logic              flush = 1'b1;
    logic [PW-1:0]     pc_o;
    logic [1:0]        f_op;
    logic [AW-1:0]     f_s1, f_s2, f_d;
    logic [NR*DW-1:0]  rf_o;

    int n_checks = 0;
    int n_fail   = 0;

    logic [1:0]    p_op [MAXP];
    logic [AW-1:0] p_s1 [MAXP];
    logic [AW-1:0] p_s2 [MAXP];
    logic [AW-1:0] p_d  [MAXP];
    int            prog_len = 0;
    logic [DW-1:0] m_rf [NR];

    always #(CLK_PERIOD/2) clk = ~clk;

    // Instruction store: combinational answer to pc_o.
    assign f_op = (int'(pc_o) < prog_len) ? p_op[pc_o[3:0]] : 2'b00;
    assign f_s1 = (int'(pc_o) < prog_len) ? p_s1[pc_o[3:0]] : '0;
    assign f_s2 = (int'(pc_o) < prog_len) ? p_s2[pc_o[3:0]] : '0;
    assign f_d  = (int'(pc_o) < prog_len) ? p_d[pc_o[3:0]]  : '0;

    fwd_pipe_core #(
        .NUM_REGS     (NR),
        .DATA_W       (DW),
        .PC_W         (PW),
        .RF_INIT_BASE (IB),
        .RF_INIT_STEP (IS)
    ) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .pc_o       (pc_o),
        .fetch_op   (f_op),
        .fetch_src1 (f_s1),
        .fetch_src2 (f_s2),
        .fetch_dest (f_d),
        .rf_o       (rf_o)
    );

    // R7 encoding: 00 add, 01 sub, 10 and, 11 xor.
    function automatic logic [15:0] ref_alu(input logic [1:0] op,
                                            input logic [15:0] a,
                                            input logic [15:0] b);
        case (op)
            2'b00:   return a + b;
            2'b01:   return a - b;
            2'b10:   return a & b;
            default: return a ^ b;
        endcase
    endfunction

    // R1 reset value of register i.
    function automatic logic [15:0] init_val(input int i);
        return IB + (16'(i) * IS);
    endfunction

    function automatic logic [15:0] rf_reg(input int i);
        return rf_o[i*DW +: DW];
    endfunction

    // R3: cycles = instructions + first-operand dependences on the previous one.
    function automatic int exp_cycles();
        int n = prog_len;
        for (int i = 1; i < prog_len; i++) begin
            if (p_d[i-1] == p_s1[i]) n++;
        end
        return n;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic set_instr(input int idx, input logic [1:0] op,
                             input int d, input int s1, input int s2);
        p_op[idx] = op;
        p_d[idx]  = AW'(d);
        p_s1[idx] = AW'(s1);
        p_s2[idx] = AW'(s2);
    endtask

    task automatic do_reset();
        flush    = 1'b1;
        prog_len = 0;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NR; i++) m_rf[i] = init_val(i);
        @(negedge clk);
    endtask

    // R9 reference: one instruction at a time, in order.
    task automatic model_run();
        for (int i = 0; i < prog_len; i++) begin
            m_rf[p_d[i]] = ref_alu(p_op[i], m_rf[p_s1[i]], m_rf[p_s2[i]]);
        end
    endtask

    task automatic check_rf(input string req);
        for (int i = 0; i < NR; i++) begin
            chk(rf_reg(i) == m_rf[i], req, $sformatf("reg %0d", i),
                32'(rf_reg(i)), 32'(m_rf[i]));
        end
    endtask

    // Run the loaded program; optional flush of flen cycles after cycle fat.
    task automatic run_prog(input string req, input int fat, input int flen);
        int cyc = 0;
        bit done = 1'b0;
        int expc = exp_cycles() + ((fat > 0) ? flen : 0);
        flush = 1'b0;
        while (!done && cyc < 200) begin
            @(posedge clk);
            @(negedge clk);
            cyc++;
            if (int'(pc_o) == prog_len) begin
                done = 1'b1;
            end else if (cyc == fat) begin
                logic [PW-1:0] held;
                held  = pc_o;
                flush = 1'b1;
                for (int k = 0; k < flen; k++) begin
                    @(posedge clk);
                    @(negedge clk);
                    cyc++;
                    chk(pc_o == held, "R2", "pc held under flush",
                        32'(pc_o), 32'(held));
                end
                flush = 1'b0;
            end
        end
        flush = 1'b1;
        chk(done, req, "program reached its end", 32'(pc_o), 32'(prog_len));
        chk(cyc == expc, "R3", "cycles to fetch the program", 32'(cyc), 32'(expc));
        repeat (3) @(negedge clk);
        model_run();
        check_rf(req);
    endtask

    task automatic t_reset();
        do_reset();
        chk(pc_o == '0, "R1", "pc after reset", 32'(pc_o), 32'd0);
        for (int i = 0; i < NR; i++) begin
            chk(rf_reg(i) == init_val(i), "R1", $sformatf("reg %0d after reset", i),
                32'(rf_reg(i)), 32'(init_val(i)));
        end
        repeat (4) @(negedge clk);
        chk(pc_o == '0, "R2", "pc held while flushing", 32'(pc_o), 32'd0);
        check_rf("R6");
    endtask

    task automatic t_alu();
        do_reset();
        set_instr(0, 2'b00, 0, 1, 2);
        set_instr(1, 2'b01, 3, 1, 7);
        set_instr(2, 2'b10, 4, 5, 6);
        set_instr(3, 2'b11, 5, 6, 7);
        prog_len = 4;
        run_prog("R7", 0, 0);
        chk(rf_reg(3) == 16'hF9FA, "R7", "sub wraps", 32'(rf_reg(3)), 32'hF9FA);
    endtask

    task automatic t_latency();
        logic [15:0] want;
        do_reset();
        set_instr(0, 2'b00, 3, 1, 2);
        prog_len = 1;
        want = init_val(1) + init_val(2);
        flush = 1'b0;
        @(posedge clk);
        @(negedge clk);
        flush = 1'b1;
        chk(pc_o == 8'd1, "R2", "pc after one fetch", 32'(pc_o), 32'd1);
        chk(rf_reg(3) == init_val(3), "R8", "no write after edge 1",
            32'(rf_reg(3)), 32'(init_val(3)));
        @(negedge clk);
        chk(rf_reg(3) == init_val(3), "R8", "no write after edge 2",
            32'(rf_reg(3)), 32'(init_val(3)));
        @(negedge clk);
        chk(rf_reg(3) == want, "R8", "write after edge 3", 32'(rf_reg(3)), 32'(want));
    endtask

    task automatic t_stall();
        do_reset();
        set_instr(0, 2'b00, 4, 1, 2);
        set_instr(1, 2'b01, 5, 4, 3);
        set_instr(2, 2'b11, 6, 5, 1);
        prog_len = 3;
        run_prog("R3", 0, 0);
    endtask

    task automatic t_forward();
        do_reset();
        set_instr(0, 2'b11, 4, 1, 2);
        set_instr(1, 2'b00, 5, 0, 4);
        set_instr(2, 2'b10, 6, 3, 5);
        prog_len = 3;
        run_prog("R4", 0, 0);
    endtask

    task automatic t_writethrough();
        do_reset();
        set_instr(0, 2'b00, 6, 1, 3);
        set_instr(1, 2'b11, 7, 2, 2);
        set_instr(2, 2'b00, 0, 6, 6);
        set_instr(3, 2'b01, 1, 7, 0);
        prog_len = 4;
        run_prog("R5", 0, 0);
    endtask

    task automatic t_flush();
        do_reset();
        set_instr(0, 2'b00, 1, 1, 2);
        set_instr(1, 2'b00, 3, 3, 1);
        set_instr(2, 2'b00, 2, 2, 3);
        prog_len = 3;
        run_prog("R6", 1, 2);
    endtask

    task automatic t_mixed();
        do_reset();
        set_instr(0, 2'b00, 2, 1, 7);
        set_instr(1, 2'b01, 3, 2, 2);
        set_instr(2, 2'b11, 4, 3, 2);
        set_instr(3, 2'b10, 3, 1, 4);
        set_instr(4, 2'b00, 5, 3, 3);
        set_instr(5, 2'b01, 6, 0, 5);
        set_instr(6, 2'b11, 7, 6, 6);
        set_instr(7, 2'b00, 0, 7, 0);
        prog_len = 8;
        run_prog("R9", 0, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog (all requirements): actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_alu();
        t_latency();
        t_stall();
        t_forward();
        t_writethrough();
        t_flush();
        t_mixed();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule